// File: doc/BRIEF.md
# Legacy Keyboard Controller Emulation

This block lets a USB host controller take the place of an old keyboard/mouse controller. Before an operating-system driver is loaded, firmware reaches the keyboard through two legacy I/O ports: a data port (60h) and a command/status port (64h). The block catches host byte writes to either port and holds the byte in an input register. It answers host reads with a byte that emulation software prepared earlier (data port) or with a status byte (command port). It also keeps the input-full, output-full and command/data flags that the host polls.

Emulation software services this traffic through four 32-bit memory-mapped registers: control, input, output and status. When the input-full flag goes from 0 to 1 while emulation is enabled, the block sends a one-cycle interrupt pulse so that software can fetch the byte. When emulation is disabled, host port accesses have no effect and host reads return all ones.

Top module: `kbd_emu`

## Requirements
- R1: After reset the control, input and output registers are 0, all status flags are 0, irq_o is low, and a host read of either port returns FFh.
- R2: Memory-mapped registers are word-decoded at offsets 100h (control, bit 0 = enable), 104h (input byte, bits 7:0), 108h (output byte, bits 7:0) and 10Ch (status). Status bit 0 is output-full, bit 1 is input-full and bit 3 is command/data; all other bits read 0. Any unmapped offset reads 0.
- R3: With emulation enabled, a host write to port 60h or 64h puts the written byte into the input register on the next clock edge. A host write wins over a software write to the input register in the same cycle.
- R4: A host write with emulation enabled sets input-full. It sets command/data to 1 for port 64h and to 0 for port 60h.
- R5: With emulation enabled, a host read of port 60h returns the output byte in the same cycle and clears output-full at the next edge.
- R6: With emulation enabled, a host read of port 64h returns the status byte (same layout as R2) and changes no flag.
- R7: A software write to the output register loads the byte and sets output-full.
- R8: With emulation disabled, host writes change no register or flag, and host reads return FFh. At any time, ports other than 60h/64h are ignored and read as FFh.
- R9: irq_o pulses high for exactly one cycle after an edge at which input-full went from 0 to 1 while emulation was enabled. A write made while input-full is already set gives no pulse.
- R10: A software write to the status register replaces bits 0, 1 and 3. A host port event in the same cycle takes priority for the flags it updates.
- R11: Software can write the input register directly, and the result can be read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| io_addr_i | input | 16 | Host I/O port address |
| io_rd_i | input | 1 | Host I/O read strobe |
| io_wr_i | input | 1 | Host I/O write strobe |
| io_wdata_i | input | 8 | Host I/O write byte |
| io_rdata_o | output | 8 | Host I/O read byte |
| mm_addr_i | input | 12 | Memory-mapped byte offset from the operational base |
| mm_wr_i | input | 1 | Memory-mapped write strobe |
| mm_wdata_i | input | 32 | Memory-mapped write data |
| mm_rdata_o | output | 32 | Memory-mapped read data |
| irq_o | output | 1 | Emulation interrupt pulse |

## Verification
The hardest cases to reach are the interrupt rising-edge rule and the same-cycle races. The bench first leaves input-full set and then writes a port a second time, which must give no pulse. It also drives a host data-port read in the same cycle as a software output write, and a host write in the same cycle as a software status clear, to show that the host event wins. Full 256-value byte sweeps on both ports, with emulation enabled and then disabled, cover data capture, readback and the ignore behaviour.

// File: rtl/kbd_emu_pkg.sv
package kbd_emu_pkg;
  localparam logic [11:0] OFF_CTRL = 12'h100;
  localparam logic [11:0] OFF_IN   = 12'h104;
  localparam logic [11:0] OFF_OUT  = 12'h108;
  localparam logic [11:0] OFF_STS  = 12'h10C;
  localparam int STS_OBF = 0;
  localparam int STS_IBF = 1;
  localparam int STS_CMD = 3;
endpackage

// File: rtl/kbd_emu_port_dec.sv
module kbd_emu_port_dec #(
  parameter int IO_AW = 16,
  parameter logic [IO_AW-1:0] DATA_PORT = 'h60,
  parameter logic [IO_AW-1:0] CMD_PORT  = 'h64
) (
  input  logic [IO_AW-1:0] addr_i,
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic             en_i,
  output logic             hit_data_o,
  output logic             hit_cmd_o,
  output logic             host_wr_o,
  output logic             host_rd_data_o
);
  assign hit_data_o     = en_i && (addr_i == DATA_PORT);
  assign hit_cmd_o      = en_i && (addr_i == CMD_PORT);
  assign host_wr_o      = wr_i && (hit_data_o || hit_cmd_o);
  assign host_rd_data_o = rd_i && hit_data_o;
endmodule

// File: rtl/kbd_emu_sw_if.sv
module kbd_emu_sw_if
  import kbd_emu_pkg::*;
#(
  parameter int MM_AW = 12,
  parameter int DW    = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [MM_AW-1:0] mm_addr_i,
  input  logic          mm_wr_i,
  input  logic [31:0]   mm_wdata_i,
  output logic [31:0]   mm_rdata_o,
  input  logic          host_wr_i,
  input  logic [DW-1:0] host_byte_i,
  input  logic [DW-1:0] sts_byte_i,
  output logic          en_o,
  output logic [DW-1:0] in_byte_o,
  output logic [DW-1:0] out_byte_o,
  output logic          out_wr_o,
  output logic          sts_wr_o
);
  localparam int IW = MM_AW - 2;
  localparam logic [IW-1:0] I_CTRL = IW'(OFF_CTRL >> 2);
  localparam logic [IW-1:0] I_IN   = IW'(OFF_IN >> 2);
  localparam logic [IW-1:0] I_OUT  = IW'(OFF_OUT >> 2);
  localparam logic [IW-1:0] I_STS  = IW'(OFF_STS >> 2);

  logic [IW-1:0] idx;
  logic sel_ctrl, sel_in, sel_out, sel_sts;

  assign idx      = mm_addr_i[MM_AW-1:2];
  assign sel_ctrl = idx == I_CTRL;
  assign sel_in   = idx == I_IN;
  assign sel_out  = idx == I_OUT;
  assign sel_sts  = idx == I_STS;
  assign out_wr_o = mm_wr_i && sel_out;
  assign sts_wr_o = mm_wr_i && sel_sts;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o       <= 1'b0;
      in_byte_o  <= '0;
      out_byte_o <= '0;
    end else begin
      if (mm_wr_i && sel_ctrl) en_o <= mm_wdata_i[0];
      if (out_wr_o) out_byte_o <= mm_wdata_i[DW-1:0];
      // host capture has priority over software
      if (host_wr_i) in_byte_o <= host_byte_i;
      else if (mm_wr_i && sel_in) in_byte_o <= mm_wdata_i[DW-1:0];
    end
  end

  always_comb begin
    mm_rdata_o = '0;
    unique case (1'b1)
      sel_ctrl: mm_rdata_o[0]      = en_o;
      sel_in:   mm_rdata_o[DW-1:0] = in_byte_o;
      sel_out:  mm_rdata_o[DW-1:0] = out_byte_o;
      sel_sts:  mm_rdata_o[DW-1:0] = sts_byte_i;
      default:  mm_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/kbd_emu_flags.sv
module kbd_emu_flags
  import kbd_emu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          sts_wr_i,
  input  logic [DW-1:0] sts_wdata_i,
  input  logic          out_wr_i,
  input  logic          host_wr_i,
  input  logic          host_cmd_i,
  input  logic          host_rd_data_i,
  output logic          out_full_o,
  output logic          in_full_o,
  output logic          cmd_o,
  output logic          irq_o,
  output logic [DW-1:0] sts_byte_o
);
  logic out_d, in_d, cmd_d;

  always_comb begin
    out_d = out_full_o;
    in_d  = in_full_o;
    cmd_d = cmd_o;
    if (sts_wr_i) begin
      out_d = sts_wdata_i[STS_OBF];
      in_d  = sts_wdata_i[STS_IBF];
      cmd_d = sts_wdata_i[STS_CMD];
    end
    if (out_wr_i) out_d = 1'b1;
    // host events last: they win over software
    if (host_wr_i) begin
      in_d  = 1'b1;
      cmd_d = host_cmd_i;
    end
    if (host_rd_data_i) out_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_full_o <= 1'b0;
      in_full_o  <= 1'b0;
      cmd_o      <= 1'b0;
      irq_o      <= 1'b0;
    end else begin
      out_full_o <= out_d;
      in_full_o  <= in_d;
      cmd_o      <= cmd_d;
      irq_o      <= en_i && in_d && !in_full_o;
    end
  end

  always_comb begin
    sts_byte_o          = '0;
    sts_byte_o[STS_OBF] = out_full_o;
    sts_byte_o[STS_IBF] = in_full_o;
    sts_byte_o[STS_CMD] = cmd_o;
  end
endmodule

// File: rtl/kbd_emu.sv
module kbd_emu #(
  parameter int IO_AW = 16,
  parameter int MM_AW = 12,
  parameter int DW    = 8,
  parameter logic [IO_AW-1:0] DATA_PORT = 'h60,
  parameter logic [IO_AW-1:0] CMD_PORT  = 'h64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IO_AW-1:0] io_addr_i,
  input  logic             io_rd_i,
  input  logic             io_wr_i,
  input  logic [DW-1:0]    io_wdata_i,
  output logic [DW-1:0]    io_rdata_o,
  input  logic [MM_AW-1:0] mm_addr_i,
  input  logic             mm_wr_i,
  input  logic [31:0]      mm_wdata_i,
  output logic [31:0]      mm_rdata_o,
  output logic             irq_o
);
  logic en, hit_data, hit_cmd, host_wr, host_rd_data;
  logic out_wr, sts_wr, out_full, in_full, cmd;
  logic [DW-1:0] in_byte, out_byte, sts_byte;

  kbd_emu_port_dec #(.IO_AW(IO_AW), .DATA_PORT(DATA_PORT), .CMD_PORT(CMD_PORT)) u_dec (
    .addr_i(io_addr_i), .rd_i(io_rd_i), .wr_i(io_wr_i), .en_i(en),
    .hit_data_o(hit_data), .hit_cmd_o(hit_cmd),
    .host_wr_o(host_wr), .host_rd_data_o(host_rd_data)
  );

  kbd_emu_sw_if #(.MM_AW(MM_AW), .DW(DW)) u_sw (
    .clk_i, .rst_ni, .mm_addr_i, .mm_wr_i, .mm_wdata_i, .mm_rdata_o,
    .host_wr_i(host_wr), .host_byte_i(io_wdata_i), .sts_byte_i(sts_byte),
    .en_o(en), .in_byte_o(in_byte), .out_byte_o(out_byte),
    .out_wr_o(out_wr), .sts_wr_o(sts_wr)
  );

  kbd_emu_flags #(.DW(DW)) u_flags (
    .clk_i, .rst_ni, .en_i(en), .sts_wr_i(sts_wr), .sts_wdata_i(mm_wdata_i[DW-1:0]),
    .out_wr_i(out_wr), .host_wr_i(host_wr), .host_cmd_i(hit_cmd),
    .host_rd_data_i(host_rd_data), .out_full_o(out_full), .in_full_o(in_full),
    .cmd_o(cmd), .irq_o, .sts_byte_o(sts_byte)
  );

  always_comb begin
    if (hit_data)     io_rdata_o = out_byte;
    else if (hit_cmd) io_rdata_o = sts_byte;
    else              io_rdata_o = '1;
  end
endmodule

// File: rtl/kbd_emu_chk.sv
module kbd_emu_chk #(
  parameter int IO_AW = 16,
  parameter int MM_AW = 12,
  parameter int DW    = 8,
  parameter logic [IO_AW-1:0] DATA_PORT = 'h60,
  parameter logic [IO_AW-1:0] CMD_PORT  = 'h64
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [IO_AW-1:0] io_addr_i,
  input logic             io_rd_i,
  input logic             io_wr_i,
  input logic [DW-1:0]    io_wdata_i,
  input logic [MM_AW-1:0] mm_addr_i,
  input logic             mm_wr_i,
  input logic             irq_o,
  input logic             en,
  input logic             in_full,
  input logic             out_full,
  input logic             cmd,
  input logic [DW-1:0]    in_byte
);
  logic port_hit, mm_out;
  assign port_hit = (io_addr_i == DATA_PORT) || (io_addr_i == CMD_PORT);
  assign mm_out   = mm_wr_i && (mm_addr_i[MM_AW-1:2] == (MM_AW-2)'(12'h108 >> 2));

  // R3
  host_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en && io_wr_i && port_hit |=> in_byte == $past(io_wdata_i));
  // R4
  in_full_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en && io_wr_i && port_hit |=> in_full && (cmd == $past(io_addr_i == CMD_PORT)));
  // R5
  rd_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en && io_rd_i && (io_addr_i == DATA_PORT) |=> !out_full);
  // R7
  out_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mm_out && !(en && io_rd_i && (io_addr_i == DATA_PORT)) |=> out_full);
  // R8
  dis_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en && !mm_wr_i |=> $stable(in_byte) && $stable(in_full) && $stable(out_full) && $stable(cmd));
  // R9
  irq_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> in_full && !$past(in_full));
endmodule

bind kbd_emu kbd_emu_chk #(.IO_AW(IO_AW), .MM_AW(MM_AW), .DW(DW),
  .DATA_PORT(DATA_PORT), .CMD_PORT(CMD_PORT)) u_chk (
  .clk_i, .rst_ni, .io_addr_i, .io_rd_i, .io_wr_i, .io_wdata_i,
  .mm_addr_i, .mm_wr_i, .irq_o, .en, .in_full, .out_full, .cmd, .in_byte
);

// File: tb/kbd_emu_tb.sv
`timescale 1ns/1ps
module kbd_emu_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] io_addr = '0;
  logic io_rd = 1'b0, io_wr = 1'b0;
  logic [7:0] io_wdata = '0, io_rdata;
  logic [11:0] mm_addr = '0;
  logic mm_wr = 1'b0;
  logic [31:0] mm_wdata = '0, mm_rdata;
  logic irq;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  kbd_emu dut_i (
    .clk_i(clk), .rst_ni(rst_n), .io_addr_i(io_addr), .io_rd_i(io_rd), .io_wr_i(io_wr),
    .io_wdata_i(io_wdata), .io_rdata_o(io_rdata), .mm_addr_i(mm_addr), .mm_wr_i(mm_wr),
    .mm_wdata_i(mm_wdata), .mm_rdata_o(mm_rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic mm_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); mm_addr = a; mm_wdata = d; mm_wr = 1'b1;
    @(negedge clk); mm_wr = 1'b0;
  endtask

  task automatic mm_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); mm_addr = a; #1 d = mm_rdata;
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk); io_wr = 1'b0;
  endtask

  task automatic io_read(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk); io_addr = a; io_rd = 1'b1; #1 d = io_rdata;
    @(negedge clk); io_rd = 1'b0;
  endtask

  function automatic logic [31:0] sts(input bit obf, input bit ibf, input bit c);
    return {28'd0, c, 1'b0, ibf, obf};
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [7:0] b;
    #20 rst_n = 1'b1;
    // R1 reset state
    mm_read(12'h100, r); chk("R1 ctrl", r, 0);
    mm_read(12'h104, r); chk("R1 input", r, 0);
    mm_read(12'h108, r); chk("R1 output", r, 0);
    mm_read(12'h10C, r); chk("R1 status", r, 0);
    chk("R1 irq", {31'd0, irq}, 0);
    io_read(16'h60, b); chk("R1 rd60", {24'd0, b}, 32'hFF);
    io_read(16'h64, b); chk("R1 rd64", {24'd0, b}, 32'hFF);
    // R2 unmapped offsets
    mm_read(12'h000, r); chk("R2 unmapped", r, 0);
    mm_read(12'h110, r); chk("R2 unmapped", r, 0);

    // R8 disabled sweep: writes ignored, reads FFh
    for (int v = 0; v < 256; v++) begin
      io_write((v % 2) ? 16'h64 : 16'h60, 8'(v));
      io_read((v % 2) ? 16'h60 : 16'h64, b);
      if (b !== 8'hFF || irq !== 1'b0) chk("R8 dis read", {23'd0, irq, b}, 32'hFF);
    end
    mm_read(12'h104, r); chk("R8 input untouched", r, 0);
    mm_read(12'h10C, r); chk("R8 status untouched", r, 0);

    mm_write(12'h100, 32'h1);
    mm_read(12'h100, r); chk("R2 ctrl enable", r, 1);

    // R3 R4 R9 enabled write sweep over both ports
    for (int v = 0; v < 512; v++) begin
      bit c = v[8];
      mm_write(12'h10C, 32'h0);
      io_write(c ? 16'h64 : 16'h60, 8'(v));
      if (irq !== 1'b1) chk("R9 irq pulse", {31'd0, irq}, 1);
      mm_read(12'h104, r);
      if (irq !== 1'b0) chk("R9 irq one cycle", {31'd0, irq}, 0);
      if (r !== {24'd0, 8'(v)}) chk("R3 capture", r, {24'd0, 8'(v)});
      mm_read(12'h10C, r);
      if (r !== sts(0, 1, c)) chk("R4 flags", r, sts(0, 1, c));
    end
    chk("R3 sweep done", 1, 1);
    // R9 second write while full: no pulse; cmd follows port
    io_write(16'h60, 8'hA5);
    chk("R9 no pulse when full", {31'd0, irq}, 0);
    mm_read(12'h10C, r); chk("R4 cmd to data port", r, sts(0, 1, 0));
    // R6 read of status port
    io_read(16'h64, b); chk("R6 rd64", {24'd0, b}, sts(0, 1, 0));
    mm_read(12'h10C, r); chk("R6 no change", r, sts(0, 1, 0));

    // R5 R7 output sweep
    for (int v = 0; v < 256; v++) begin
      mm_write(12'h108, 32'hABCD_0000 | v);
      mm_read(12'h10C, r);
      if (r[0] !== 1'b1) chk("R7 obf set", r, sts(1, 1, 0));
      io_read(16'h60, b);
      if (b !== 8'(v)) chk("R5 rd60", {24'd0, b}, {24'd0, 8'(v)});
      mm_read(12'h10C, r);
      if (r !== sts(0, 1, 0)) chk("R5 obf clear", r, sts(0, 1, 0));
    end
    mm_read(12'h108, r); chk("R7 output reg", r, 32'hFF);

    // R10 software status write, then host write wins in same cycle
    mm_write(12'h10C, 32'hFFFF_FFFF);
    mm_read(12'h10C, r); chk("R10 sts write", r, sts(1, 1, 1));
    mm_write(12'h10C, 32'h0);
    mm_read(12'h10C, r); chk("R10 sts clear", r, 0);
    @(negedge clk);
    mm_addr = 12'h10C; mm_wdata = 32'h0; mm_wr = 1'b1;
    io_addr = 16'h64; io_wdata = 8'h3C; io_wr = 1'b1;
    @(negedge clk); mm_wr = 1'b0; io_wr = 1'b0;
    chk("R9 irq on race", {31'd0, irq}, 1);
    mm_read(12'h10C, r); chk("R10 host wins", r, sts(0, 1, 1));
    // R5/R10 read-clear beats output write in same cycle
    @(negedge clk);
    mm_addr = 12'h108; mm_wdata = 32'h77; mm_wr = 1'b1;
    io_addr = 16'h60; io_rd = 1'b1;
    @(negedge clk); mm_wr = 1'b0; io_rd = 1'b0;
    mm_read(12'h10C, r); chk("R10 rd clear wins", r, sts(0, 1, 1));

    // R11 software input write; R3 host beats it in same cycle
    mm_write(12'h104, 32'h0000_005A);
    mm_read(12'h104, r); chk("R11 sw input", r, 32'h5A);
    @(negedge clk);
    mm_addr = 12'h104; mm_wdata = 32'h11; mm_wr = 1'b1;
    io_addr = 16'h60; io_wdata = 8'h99; io_wr = 1'b1;
    @(negedge clk); mm_wr = 1'b0; io_wr = 1'b0;
    mm_read(12'h104, r); chk("R3 host over sw", r, 32'h99);

    // R8 other port ignored while enabled
    mm_write(12'h10C, 32'h0);
    io_write(16'h61, 8'h42);
    io_read(16'h65, b); chk("R8 other port rd", {24'd0, b}, 32'hFF);
    mm_read(12'h10C, r); chk("R8 other port no flags", r, 0);
    mm_read(12'h104, r); chk("R8 other port no capture", r, 32'h99);
    chk("R8 other port no irq", {31'd0, irq}, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule